// File: doc/BRIEF.md
# Multicart Outer-Bank Supervisor Registers

This block is the supervisor register set that sits in front of the inner mapper of a multi-game cartridge. It watches CPU accesses to a small set of addresses inside the 0x5000–0x5FFF window. From those writes it keeps four things:

- the number of the inner-mapper mode in use, together with four mode flags;
- a miscellaneous byte that locks itself once its top bit is set;
- a second miscellaneous byte that only one board variant uses;
- a 15-bit outer PRG base.

The bits of the PRG base come from several of those registers.

The block also forwards serial-EEPROM select, clock and data levels. Which address and which data bits carry those levels depends on a board-variant strap input. The block returns the EEPROM output bit on two read addresses.

Each write that selects a mode also produces a one-cycle request that clears the inner mapper's registers and any pending interrupt. The variant strap is expected to change only while reset is asserted.

Top module: `mcart_outer_regs`

## Requirements
- R1: While reset is asserted the block holds PRG base 0x7FF0, flags 0xF, misc 0x00, misc2 0x00, mode equal to {variant, 4'h0}, EEPROM select 1, clock 0, data 0, and no clear request.
- R2: A write to 0x5700 sets mode to {variant, data[7:4]}, flags to data[3:0], and PRG base bit 4 to data[0].
- R3: clear_req is high for exactly the one cycle after the clock edge that accepts a write to 0x5700, and low otherwise.
- R4: A write to 0x5701 loads data[7:0] into PRG base bits 12:5 and leaves the other bits unchanged.
- R5: A write to 0x5601 stores misc only while misc bit 7 is 0. Once that bit is 1, later writes to 0x5601 leave misc unchanged until reset.
- R6: With variant 0, an accepted write to 0x5601 also copies data[4] into PRG base bit 13. With any other variant, bit 13 is left unchanged.
- R7: PRG base bit 14 stays 1 and bits 3:0 stay 0 at all times.
- R8: With variant 0, a write to 0x5301 sets EEPROM select, clock and data from data bits 2, 1 and 0.
- R9: With variant 1, every write to 0x5601 sets EEPROM select, clock and data from data bits 4, 1 and 0, even when misc is locked.
- R10: No write other than those in R8 and R9 changes the EEPROM pins. For a variant of 2 or above the pins never change after reset.
- R11: A write to 0x5702 stores data into misc2 only when the variant is 1.
- R12: A read of 0x5301 or 0x5601 returns 0x80 when the EEPROM output is 1 and 0x00 when it is 0. Every other address returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant | input | 4 | Board-variant strap |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Read data for the current address |
| eep_do | input | 1 | EEPROM serial output |
| eep_sel | output | 1 | EEPROM select level |
| eep_clk | output | 1 | EEPROM clock level |
| eep_di | output | 1 | EEPROM data-in level |
| mode | output | 8 | Inner-mapper mode number |
| flags | output | 4 | Mode flags |
| misc | output | 8 | Lockable miscellaneous register |
| misc2 | output | 8 | Variant-1 miscellaneous register |
| prg_base | output | 15 | Outer PRG base |
| clear_req | output | 1 | Inner-mapper clear request pulse |

## Verification
The bench locks misc with a write that has bit 7 set, then keeps writing 0x5601. A design that ignored the lock would change misc or PRG base bit 13. A design that gated the variant-1 pin routing on the lock would stop moving the EEPROM pins.

Random writes to all three PRG-base sources are checked against the full 15-bit value, so a field placed at the wrong bit would show up. Runs with variants 0, 1 and 2 catch routing taken from the wrong address or the wrong data bits, and a misc2 that stores on the wrong variant. Back-to-back writes to 0x5700 expose a clear pulse that stretches or goes missing.

// File: rtl/mcart_outer_regs.sv
module mcart_outer_regs #(
  parameter int VAR_W  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int PRG_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VAR_W-1:0]  variant,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              eep_do,
  output logic              eep_sel,
  output logic              eep_clk,
  output logic              eep_di,
  output logic [7:0]        mode,
  output logic [3:0]        flags,
  output logic [DATA_W-1:0] misc,
  output logic [DATA_W-1:0] misc2,
  output logic [PRG_W-1:0]  prg_base,
  output logic              clear_req
);
  localparam logic [ADDR_W-1:0] A_EEP  = ADDR_W'('h5301);
  localparam logic [ADDR_W-1:0] A_MISC = ADDR_W'('h5601);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'('h5700);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'('h5701);
  localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'('h5702);
  localparam logic [PRG_W-1:0]  PRG_RST = PRG_W'('h7FF0);

  logic v0, v1, w_eep, w_misc, w_mode, w_base, w_aux, unlocked;

  assign v0       = (variant == '0);
  assign v1       = (variant == VAR_W'(1));
  assign w_eep    = wr_en && addr == A_EEP;
  assign w_misc   = wr_en && addr == A_MISC;
  assign w_mode   = wr_en && addr == A_MODE;
  assign w_base   = wr_en && addr == A_BASE;
  assign w_aux    = wr_en && addr == A_AUX;
  assign unlocked = !misc[DATA_W-1];

  assign rdata = (addr == A_EEP || addr == A_MISC) ? {eep_do, {(DATA_W-1){1'b0}}}
                                                   : {DATA_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= {variant[3:0], 4'h0};
      flags     <= 4'hF;
      misc      <= '0;
      misc2     <= '0;
      prg_base  <= PRG_RST;
      clear_req <= 1'b0;
    end else begin
      clear_req <= w_mode;
      if (w_mode) begin
        mode        <= {variant[3:0], wdata[7:4]};
        flags       <= wdata[3:0];
        prg_base[4] <= wdata[0];
      end
      if (w_base) prg_base[12:5] <= wdata[7:0];
      if (w_misc && unlocked) begin
        misc <= wdata;
        if (v0) prg_base[13] <= wdata[4];
      end
      if (w_aux && v1) misc2 <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eep_sel <= 1'b1;
      eep_clk <= 1'b0;
      eep_di  <= 1'b0;
    end else if (w_eep && v0) begin
      eep_sel <= wdata[2];
      eep_clk <= wdata[1];
      eep_di  <= wdata[0];
    end else if (w_misc && v1) begin
      eep_sel <= wdata[4];
      eep_clk <= wdata[1];
      eep_di  <= wdata[0];
    end
  end

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misc[DATA_W-1] |=> $stable(misc));
  // R7
  prg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prg_base[14] && prg_base[3:0] == 4'h0);
  // R11
  aux_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(misc2));
  // R10
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!v0 && !v1) |=> $stable({eep_sel, eep_clk, eep_di}));
  // R3
  clear_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |-> mode[7:4] == variant[3:0]);
endmodule

// File: tb/tb_mcart_outer_regs.sv
module tb_mcart_outer_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, eep_do = 0;
  logic [3:0] variant = 0;
  logic [15:0] addr = 16'h5000;
  logic [7:0] wdata = 0, rdata, mode, misc, misc2;
  logic [3:0] flags;
  logic [14:0] prg_base;
  logic eep_sel, eep_clk, eep_di, clear_req;

  int checks = 0, fails = 0;

  logic [7:0] e_mode, e_misc, e_misc2;
  logic [3:0] e_flags;
  logic [14:0] e_prg;
  logic e_sel, e_clk, e_di;

  mcart_outer_regs dut (.clk(clk), .rst_n(rst_n), .variant(variant), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .eep_do(eep_do), .eep_sel(eep_sel),
    .eep_clk(eep_clk), .eep_di(eep_di), .mode(mode), .flags(flags), .misc(misc),
    .misc2(misc2), .prg_base(prg_base), .clear_req(clear_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    e_mode = {variant, 4'h0}; e_flags = 4'hF; e_misc = 0; e_misc2 = 0;
    e_prg = 15'h7FF0; e_sel = 1; e_clk = 0; e_di = 0;
  endtask

  task automatic do_reset(logic [3:0] v);
    @(negedge clk); rst_n = 0; variant = v; wr_en = 0;
    repeat (2) @(negedge clk);
    model_reset();
    chk("R1 mode", mode, e_mode); chk("R1 flags", flags, e_flags);
    chk("R1 misc", misc, 0); chk("R1 misc2", misc2, 0);
    chk("R1 prg", prg_base, 15'h7FF0);
    chk("R1 pins", {eep_sel, eep_clk, eep_di}, 3'b100); chk("R1 clr", clear_req, 0);
    rst_n = 1;
  endtask

  function automatic logic [14:0] prg_after(logic [14:0] p, logic [15:0] a, logic [7:0] d,
                                            logic [3:0] v, logic [7:0] m);
    logic [14:0] r = p;
    if (a == 16'h5700) r[4] = d[0];
    if (a == 16'h5701) r[12:5] = d;
    if (a == 16'h5601 && !m[7] && v == 0) r[13] = d[4];
    return r;
  endfunction

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    e_prg = prg_after(e_prg, a, d, variant, e_misc);
    if (a == 16'h5700) begin e_mode = {variant, d[7:4]}; e_flags = d[3:0]; end
    if (a == 16'h5301 && variant == 0) {e_sel, e_clk, e_di} = {d[2], d[1], d[0]};
    if (a == 16'h5601 && variant == 1) {e_sel, e_clk, e_di} = {d[4], d[1], d[0]};
    if (a == 16'h5601 && !e_misc[7]) e_misc = d;
    if (a == 16'h5702 && variant == 1) e_misc2 = d;
    @(negedge clk); wr_en = 0;
    chk("R3 pulse", clear_req, a == 16'h5700);
    chk("R2 mode", mode, e_mode); chk("R2 flags", flags, e_flags);
    chk("R4 R6 R7 prg", prg_base, e_prg);
    chk("R5 misc", misc, e_misc); chk("R11 misc2", misc2, e_misc2);
    chk("R8 R9 R10 pins", {eep_sel, eep_clk, eep_di}, {e_sel, e_clk, e_di});
  endtask

  task automatic rd(logic [15:0] a, logic bit_in);
    @(negedge clk); addr = a; eep_do = bit_in; #1;
    chk("R12 read", rdata, (a == 16'h5301 || a == 16'h5601) ? {bit_in, 7'h0} : 8'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] alist [6] = '{16'h5301, 16'h5601, 16'h5700, 16'h5701, 16'h5702, 16'h5123};
    void'($urandom(32'h1234));
    for (int v = 0; v < 3; v++) begin
      do_reset(v[3:0]);
      wr(16'h5700, 8'hA5);
      wr(16'h5700, 8'h3C);
      @(negedge clk); chk("R3 single", clear_req, 0);
      wr(16'h5701, 8'hFF); wr(16'h5701, 8'h00);
      wr(16'h5301, 8'h07); wr(16'h5301, 8'h02);
      wr(16'h5601, 8'h10); wr(16'h5601, 8'h13);
      wr(16'h5601, 8'h80);
      wr(16'h5601, 8'h13); wr(16'h5601, 8'h02);
      wr(16'h5702, 8'h5A);
      rd(16'h5301, 1); rd(16'h5601, 0); rd(16'h5601, 1); rd(16'h5700, 1); rd(16'h5FFF, 0);
      do_reset(v[3:0]);
      for (int i = 0; i < 300; i++) begin
        logic [7:0] d = 8'($urandom);
        if (i < 200) d[7] = 0;
        wr(alist[$urandom % 6], d);
        if (i % 25 == 0) rd(alist[$urandom % 6], 1'($urandom));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule